// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits behind a serial-memory slave engine and gathers the data bytes of one write command into a small page latch. The engine gives it a start address when the word address has been received. It then strobes each data byte as that byte is acknowledged, and pulses a stop input when the bus master ends the command. At that stop pulse the block decides whether a programming cycle runs. If one runs, the latched bytes are written into a synchronous byte-wide memory array, one per clock, at the start of a fixed, self-timed busy interval. The engine reads the busy output and withholds acknowledges while it is high, so the master can poll for completion.

Only the low offset bits of the address advance as bytes arrive. A long burst therefore stays inside one page and wraps over its own earlier bytes. A write-protect level is looked at only on the stop pulse. A protected command still has its bytes accepted, but it ends with nothing written and no busy period. A per-offset valid mask restricts the commit to the offsets that were actually loaded.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, busy and memWe are low, and memWe is never high while busy is low.
- R2: Each accepted byte is stored at the current page offset. The offset is the low log2(PAGE_BYTES) bits of the address and advances by one, wrapping within the page. The upper address bits keep the value loaded with the start address, and every commit address carries them.
- R3: When more than PAGE_BYTES bytes arrive before stop, the offset wraps and the later bytes replace the earlier ones at the same offsets. The commit writes the last value received for each offset.
- R4: The commit writes only the offsets that were loaded. It writes exactly one byte per clock in ascending offset order, and the first write is in the first busy cycle.
- R5: A stop pulse with loaded bytes and write-protect low raises busy on the next cycle. Busy then stays high for exactly CYCLE_CLKS cycles.
- R6: A stop pulse with no loaded bytes (an address-only command) starts no cycle: busy stays low and nothing is written.
- R7: A stop pulse seen with write-protect high starts no cycle and writes nothing. It discards the loaded bytes, so a later stop with no new bytes also writes nothing.
- R8: Changes on write-protect after the stop pulse do not alter a cycle already started: it keeps its writes and its full length.
- R9: Address loads, byte strobes and stop pulses that arrive while busy is high are ignored. They neither add bytes nor start a further cycle.
- R10: A new address load before a stop discards the bytes of the earlier command, as happens after a repeated start. Only bytes received after the new load are committed.
- R11: The write-protect level while bytes are being received has no effect. Bytes are accepted under protection, and only the level at the stop pulse decides the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startAddr | input | ADDR_W | Word address of the first byte of a write command |
| addrLoad | input | 1 | One-cycle pulse: take startAddr and open a new command |
| dataByte | input | DATA_W | Received data byte |
| dataStrobe | input | 1 | One-cycle pulse: dataByte has been accepted |
| stopPulse | input | 1 | One-cycle pulse: stop condition seen on the bus |
| wpIn | input | 1 | Write-protect level, sampled with stopPulse |
| busy | output | 1 | High during the self-timed write cycle |
| memWe | output | 1 | Memory array write enable |
| memAddr | output | ADDR_W | Memory array write address |
| memWdata | output | DATA_W | Memory array write data |

## Verification
Several properties are checked on every cycle. A write never happens outside busy. Busy only rises after an unprotected stop, and a protected stop keeps it low. Every busy period lasts exactly CYCLE_CLKS cycles. A cycle opens with a write, and consecutive writes stay in one page with strictly rising offsets. Only the bench scenarios can show which values land where. That covers the wrap overwrite, the exact set of offsets committed, the discarding of bytes after a protected stop or a fresh address load, and the inertness of the block while busy. The bench sweeps burst lengths from zero to past a full page at several start offsets and computes the expected writes arithmetically.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;   // open new command: take base/offset, clear mask
    logic takeByte;   // latch byte at current offset, advance offset
    logic dropAll;    // clear the valid mask without writing
    logic retire;     // clear the head slot after its write
  } pcbStrobe_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_CYCLE = 1'b1
  } pcbState_t;

endpackage

// File: rtl/pcb_datapath.sv
module pcb_datapath
  import pcb_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pcbStrobe_t        strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] dataByte,
  output logic              anyValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - OFF_W;

  logic [BASE_W-1:0]     pageBase;
  logic [OFF_W-1:0]      wrOff;
  logic [PAGE_BYTES-1:0] validMask;
  logic [DATA_W-1:0]     latchMem [PAGE_BYTES];
  logic [OFF_W-1:0]      headIdx;

  // page base and in-page write pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pageBase <= '0;
      wrOff    <= '0;
    end else if (strb.loadAddr) begin
      pageBase <= startAddr[ADDR_W-1:OFF_W];
      wrOff    <= startAddr[OFF_W-1:0];
    end else if (strb.takeByte) begin
      wrOff    <= wrOff + 1'b1;   // wraps inside the page
    end
  end

  // one latch slot and valid bit per page offset
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hitWr;
    logic hitRet;
    assign hitWr  = strb.takeByte && (wrOff == OFF_W'(g));
    assign hitRet = strb.retire && (headIdx == OFF_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           validMask[g] <= 1'b0;
      else if (strb.loadAddr || strb.dropAll) validMask[g] <= 1'b0;
      else if (hitWr)                       validMask[g] <= 1'b1;
      else if (hitRet)                      validMask[g] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (hitWr) latchMem[g] <= dataByte;
    end
  end

  // lowest loaded offset is the next one to commit
  always_comb begin
    headIdx = '0;
    for (int i = PAGE_BYTES - 1; i >= 0; i--) begin
      if (validMask[i]) headIdx = OFF_W'(i);
    end
  end

  assign anyValid = |validMask;
  assign memAddr  = {pageBase, headIdx};
  assign memWdata = latchMem[headIdx];

endmodule

// File: rtl/pcb_ctrl.sv
module pcb_ctrl
  import pcb_pkg::*;
#(
  parameter int CYCLE_CLKS = 625000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addrLoad,
  input  logic       dataStrobe,
  input  logic       stopPulse,
  input  logic       wpIn,
  input  logic       anyValid,
  output pcbStrobe_t strb,
  output logic       busy,
  output logic       memWe
);

  localparam int TMR_W = $clog2(CYCLE_CLKS + 1);

  pcbState_t        state;
  logic [TMR_W-1:0] timer;
  logic             startCycle;

  assign startCycle = (state == ST_IDLE) && stopPulse && anyValid && !wpIn;

  always_comb begin
    strb = '0;
    if (state == ST_IDLE) begin
      strb.loadAddr = addrLoad && !stopPulse;
      strb.takeByte = dataStrobe && !addrLoad && !stopPulse;
      strb.dropAll  = stopPulse && !startCycle;
    end else begin
      strb.retire   = anyValid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      timer <= '0;
    end else if (state == ST_IDLE) begin
      if (startCycle) begin
        state <= ST_CYCLE;
        timer <= TMR_W'(CYCLE_CLKS - 1);
      end
    end else if (timer == '0) begin
      state <= ST_IDLE;
    end else begin
      timer <= timer - 1'b1;
    end
  end

  assign busy  = (state == ST_CYCLE);
  assign memWe = busy && anyValid;

endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
  import pcb_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              addrLoad,
  input  logic [DATA_W-1:0] dataByte,
  input  logic              dataStrobe,
  input  logic              stopPulse,
  input  logic              wpIn,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  pcbStrobe_t strb;
  logic       anyValid;

  pcb_ctrl #(
    .CYCLE_CLKS(CYCLE_CLKS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .addrLoad  (addrLoad),
    .dataStrobe(dataStrobe),
    .stopPulse (stopPulse),
    .wpIn      (wpIn),
    .anyValid  (anyValid),
    .strb      (strb),
    .busy      (busy),
    .memWe     (memWe)
  );

  pcb_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .startAddr(startAddr),
    .dataByte (dataByte),
    .anyValid (anyValid),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 625000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stopPulse,
  input logic              wpIn,
  input logic              busy,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);

  localparam int OFF_W = $clog2(PAGE_BYTES);

  int runLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    runLen <= 0;
    else if (busy) runLen <= runLen + 1;
    else           runLen <= 0;
  end

  a_r1_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> busy);

  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (runLen == CYCLE_CLKS));

  a_r5_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stopPulse) && !$past(wpIn)));

  a_r7_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (stopPulse && !busy && wpIn) |=> !busy);

  a_r4_first_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> memWe);

  a_r2_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe && $past(memWe)) |->
      (memAddr[ADDR_W-1:OFF_W] == $past(memAddr[ADDR_W-1:OFF_W])));

  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe && $past(memWe)) |->
      (memAddr[OFF_W-1:0] > $past(memAddr[OFF_W-1:0])));

endmodule

bind page_commit_buf pcb_checker #(
  .ADDR_W    (ADDR_W),
  .PAGE_BYTES(PAGE_BYTES),
  .CYCLE_CLKS(CYCLE_CLKS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stopPulse(stopPulse),
  .wpIn     (wpIn),
  .busy     (busy),
  .memWe    (memWe),
  .memAddr  (memAddr)
);

// File: tb/page_commit_buf_bench.sv
module page_commit_buf_bench;

  localparam int AW    = 13;
  localparam int DW    = 8;
  localparam int PB    = 32;
  localparam int CYC   = 40;
  localparam int LOGSZ = 8192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic          addrLoad = 1'b0;
  logic [DW-1:0] dataByte = '0;
  logic          dataStrobe = 1'b0;
  logic          stopPulse = 1'b0;
  logic          wpIn = 1'b0;
  logic          busy;
  logic          memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;

  page_commit_buf #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .CYCLE_CLKS(CYC)
  ) u_page_commit_buf (
    .clk(clk), .rst_n(rst_n), .startAddr(startAddr), .addrLoad(addrLoad),
    .dataByte(dataByte), .dataStrobe(dataStrobe), .stopPulse(stopPulse),
    .wpIn(wpIn), .busy(busy), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata)
  );

  always #4 clk = ~clk;  // 125 MHz

  int nTests = 0;
  int nFail  = 0;
  int logN = 0;
  int busyTotal = 0;
  int logAddr [LOGSZ];
  int logData [LOGSZ];
  int logCyc  [LOGSZ];

  // capture every array write and count busy cycles
  always @(negedge clk) begin
    if (rst_n && busy) begin
      if (memWe) begin
        logAddr[logN % LOGSZ] = int'(memAddr);
        logData[logN % LOGSZ] = int'(memWdata);
        logCyc[logN % LOGSZ]  = busyTotal;
        logN++;
      end
      busyTotal++;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic loadAddr(int a);
    @(negedge clk); addrLoad = 1'b1; startAddr = AW'(a);
    @(negedge clk); addrLoad = 1'b0;
  endtask

  task automatic sendByte(int d);
    @(negedge clk); dataStrobe = 1'b1; dataByte = DW'(d);
    @(negedge clk); dataStrobe = 1'b0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 4000 && busy; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // stop pulse, optional disturbance during busy; returns counts
  task automatic stopAndWait(bit wpAtStop, bit wpAfter, bit poke,
                             output int writes, output int busyLen,
                             output int baseLog, output int baseBusy);
    baseLog  = logN;
    baseBusy = busyTotal;
    @(negedge clk); stopPulse = 1'b1; wpIn = wpAtStop;
    @(negedge clk); stopPulse = 1'b0; wpIn = wpAfter;
    if (poke) begin
      addrLoad = 1'b1; startAddr = AW'(13'h0100);
      @(negedge clk); addrLoad = 1'b0; dataStrobe = 1'b1; dataByte = 8'hAA;
      @(negedge clk); dataStrobe = 1'b0; stopPulse = 1'b1;
      @(negedge clk); stopPulse = 1'b0;
    end
    waitIdle();
    wpIn = 1'b0;
    writes  = logN - baseLog;
    busyLen = busyTotal - baseBusy;
  endtask

  task automatic bareStop(string tag);
    int w, b, bl, bb;
    stopAndWait(1'b0, 1'b0, 1'b0, w, b, bl, bb);
    check(w == 0, {tag, " no writes"}, w, 0);
    check(b == 0, {tag, " no busy"}, b, 0);
  endtask

  function automatic int pat(int sa, int i);
    return (i * 37 + sa + 5) & 255;
  endfunction

  task automatic runWrite(int sa, int n, bit wpLoad, bit wpStop, bit wpAfter,
                          bit poke, string tag);
    bit em [PB];
    int ed [PB];
    int expCnt, w, b, bl, bb, j;
    for (int o = 0; o < PB; o++) begin em[o] = 1'b0; ed[o] = 0; end
    wpIn = wpLoad;
    loadAddr(sa);
    for (int i = 0; i < n; i++) begin
      em[(sa + i) % PB] = 1'b1;
      ed[(sa + i) % PB] = pat(sa, i);
      sendByte(pat(sa, i));
    end
    expCnt = 0;
    if (!wpStop) for (int o = 0; o < PB; o++) if (em[o]) expCnt++;
    stopAndWait(wpStop, wpAfter, poke, w, b, bl, bb);
    check(w == expCnt, {tag, " R4 write count"}, w, expCnt);
    check(b == ((expCnt > 0) ? CYC : 0), {tag, " R5 busy length"}, b,
          (expCnt > 0) ? CYC : 0);
    j = 0;
    if (w == expCnt) begin
      for (int o = 0; o < PB; o++) begin
        if (em[o] && !wpStop) begin
          check(logAddr[(bl + j) % LOGSZ] == ((sa & ~(PB - 1)) | o),
                {tag, " R2 page address"}, logAddr[(bl + j) % LOGSZ],
                (sa & ~(PB - 1)) | o);
          check(logData[(bl + j) % LOGSZ] == ed[o], {tag, " R3 data"},
                logData[(bl + j) % LOGSZ], ed[o]);
          check(logCyc[(bl + j) % LOGSZ] - bb == j, {tag, " R4 slot"},
                logCyc[(bl + j) % LOGSZ] - bb, j);
          j++;
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int starts [4];
    starts[0] = 0; starts[1] = 5; starts[2] = 30; starts[3] = 13'h1FFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    check(memWe == 1'b0, "R1 reset write enable", int'(memWe), 0);

    // R2 R3 R4 R5 R6: burst lengths 0..34 at several offsets
    foreach (starts[s]) begin
      for (int n = 0; n <= PB + 2; n++) begin
        runWrite(starts[s], n, 1'b0, 1'b0, 1'b0, 1'b0,
                 (n == 0) ? "R6 sweep" : "sweep");
      end
    end

    // R7: protected stop writes nothing and drops the bytes
    runWrite(13'h0A47, 5, 1'b0, 1'b1, 1'b0, 1'b0, "R7 protected");
    bareStop("R7 after protected stop");

    // R11: protection while loading is irrelevant
    runWrite(13'h1234, 6, 1'b1, 1'b0, 1'b0, 1'b0, "R11 wp during load");

    // R8: protection raised right after stop
    runWrite(13'h0333, 9, 1'b0, 1'b0, 1'b1, 1'b0, "R8 wp after stop");

    // R9: traffic during busy is ignored
    runWrite(13'h0777, 4, 1'b0, 1'b0, 1'b0, 1'b1, "R9 poke");
    bareStop("R9 after busy traffic");

    // R10: reload before stop discards earlier bytes
    loadAddr(13'h0040);
    sendByte(8'h11); sendByte(8'h22); sendByte(8'h33);
    runWrite(13'h0123, 2, 1'b0, 1'b0, 1'b0, 1'b0, "R10 reload");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule